// File: doc/BRIEF.md
# Serial Port FIFO Control with Transmit Trigger

This block sits between the bus side and the serial side of an asynchronous serial port. It holds a six-bit control register and two byte queues: a transmit queue that the bus fills and the transmit shifter drains, and a receive queue that the receive shifter fills and the bus drains. It does not contain the shift engines or the baud generator. It only keeps the queues, decodes the control bits and steers the serial and handshake lines.

A two-bit field chooses the low-water mark of the transmit queue. When the transmit queue holds that many bytes or fewer, a level flag is raised so that software can refill the queue. Each queue has its own flush bit. A modem enable bit either passes the handshake lines through or forces them to their active state. In loopback, the transmit stream and the request-to-send line are turned back inside the block, and the external data pin stays idle.

Top module: `serial_fifo_ctl`

## Requirements
- R1: After reset, the control register reads 0x00, both queue counts are 0 and both overflow bits are 0. A register write takes effect on the next clock edge and reads back in bits [5:0], with bits [7:6] reading 0.
- R2: Each queue holds up to DEPTH (64) bytes and delivers them in the order they were pushed. The head byte is visible on the queue output before the pop.
- R3: The trigger field in bits [5:4] selects a threshold: 00 gives DEPTH/2 (32), 01 gives DEPTH/4 (16), 10 gives 2 and 11 gives 0. The transmit low flag is 1 exactly when the transmit count is less than or equal to the threshold.
- R4: While control bit [2] is 1, the transmit queue is held empty, transmit pushes have no effect and the transmit overflow bit is cleared.
- R5: While control bit [1] is 1, the receive queue is held empty, receive pushes have no effect and the receive overflow bit is cleared. The transmit queue is left untouched.
- R6: A push into a full queue is dropped, and the count and the stored data do not change. It sets that queue's overflow bit, which stays set until that queue's flush bit is set.
- R7: A pop from an empty queue leaves the count at 0, and the queue output reads 0 while the queue is empty.
- R8: While control bit [3] is 0, the internal clear-to-send goes to 0 (asserted) whatever the pin level, and the request-to-send pin is driven 0.
- R9: While control bit [3] is 1, the request-to-send pin is 1 when the receive count is RTS_LEVEL (60) or more, and 0 otherwise. Outside loopback, the internal clear-to-send follows the pin.
- R10: While control bit [0] is 1, the receive shifter sees the transmit shifter output and the external data pin stays at 1. When control bit [3] is also 1, the internal clear-to-send follows request-to-send. While bit [0] is 0, the data pin carries the transmit shifter output and the receive shifter sees the data input pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop the transmit head (from the shifter) |
| tx_q | output | 8 | Transmit head byte, 0 when empty |
| tx_count | output | 7 | Bytes in the transmit queue |
| tx_low | output | 1 | Transmit count at or below the selected threshold |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_push | input | 1 | Push a byte into the receive queue (from the shifter) |
| rx_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop the receive head |
| rx_q | output | 8 | Receive head byte, 0 when empty |
| rx_count | output | 7 | Bytes in the receive queue |
| rx_ovf | output | 1 | Sticky receive overflow |
| sh_txd | input | 1 | Serial output of the transmit shifter |
| txd_pin | output | 1 | External serial data output |
| rxd_pin | input | 1 | External serial data input |
| sh_rxd | output | 1 | Serial input to the receive shifter |
| cts_pin_n | input | 1 | External clear-to-send, active low |
| cts_int_n | output | 1 | Clear-to-send seen by the transmitter, active low |
| rts_pin_n | output | 1 | External request-to-send, active low |

## Verification
The bench builds the block with its default parameters: DEPTH of 64, RTS_LEVEL of 60 and 8-bit data. These make every trigger threshold reachable at its exact boundary (32, 16, 2 and 0 against one more byte). They also let a full 64-byte fill reach the overflow path in a few hundred cycles. Under the same settings the receive queue can be walked from 59 to 60 bytes to see request-to-send switch, in plain operation and through the loopback path.

// File: rtl/serial_fifo_ctl.sv
module serial_fifo_ctl #(
  parameter int DW        = 8,
  parameter int DEPTH     = 64,
  parameter int RTS_LEVEL = 60
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic                     tx_push,
  input  logic [DW-1:0]            tx_data,
  input  logic                     tx_pop,
  output logic [DW-1:0]            tx_q,
  output logic [$clog2(DEPTH):0]   tx_count,
  output logic                     tx_low,
  output logic                     tx_ovf,
  input  logic                     rx_push,
  input  logic [DW-1:0]            rx_data,
  input  logic                     rx_pop,
  output logic [DW-1:0]            rx_q,
  output logic [$clog2(DEPTH):0]   rx_count,
  output logic                     rx_ovf,
  input  logic                     sh_txd,
  output logic                     txd_pin,
  input  logic                     rxd_pin,
  output logic                     sh_rxd,
  input  logic                     cts_pin_n,
  output logic                     cts_int_n,
  output logic                     rts_pin_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] RTS_L = CW'(RTS_LEVEL);

  logic [5:0] ctrl;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctrl <= '0;
    else if (reg_wr) ctrl <= reg_wdata[5:0];

  assign reg_rdata = {2'b00, ctrl};

  wire [1:0] trig_sel = ctrl[5:4];
  wire       mce      = ctrl[3];
  wire       tx_fl    = ctrl[2];
  wire       rx_fl    = ctrl[1];
  wire       loop     = ctrl[0];

  // transmit queue
  logic [DW-1:0] tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  wire tx_put = tx_push && (tx_count != FULL);
  wire tx_get = tx_pop  && (tx_count != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0; tx_ovf <= 1'b0;
    end else if (tx_fl) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0; tx_ovf <= 1'b0;
    end else begin
      if (tx_put) tx_wp <= tx_wp + 1'b1;
      if (tx_get) tx_rp <= tx_rp + 1'b1;
      tx_count <= tx_count + CW'(tx_put) - CW'(tx_get);
      if (tx_push && !tx_put) tx_ovf <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!tx_fl && tx_put) tx_mem[tx_wp] <= tx_data;

  assign tx_q = (tx_count == '0) ? '0 : tx_mem[tx_rp];

  // receive queue
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  wire rx_put = rx_push && (rx_count != FULL);
  wire rx_get = rx_pop  && (rx_count != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0; rx_ovf <= 1'b0;
    end else if (rx_fl) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0; rx_ovf <= 1'b0;
    end else begin
      if (rx_put) rx_wp <= rx_wp + 1'b1;
      if (rx_get) rx_rp <= rx_rp + 1'b1;
      rx_count <= rx_count + CW'(rx_put) - CW'(rx_get);
      if (rx_push && !rx_put) rx_ovf <= 1'b1;
    end

  always_ff @(posedge clk)
    if (!rx_fl && rx_put) rx_mem[rx_wp] <= rx_data;

  assign rx_q = (rx_count == '0) ? '0 : rx_mem[rx_rp];

  // transmit threshold
  logic [CW-1:0] trig_lvl;
  always_comb
    case (trig_sel)
      2'd0:    trig_lvl = CW'(DEPTH / 2);
      2'd1:    trig_lvl = CW'(DEPTH / 4);
      2'd2:    trig_lvl = CW'(2);
      default: trig_lvl = '0;
    endcase

  assign tx_low = (tx_count <= trig_lvl);

  // handshake and line steering
  assign rts_pin_n = mce && (rx_count >= RTS_L);
  assign cts_int_n = mce && (loop ? rts_pin_n : cts_pin_n);
  assign txd_pin   = loop ? 1'b1   : sh_txd;
  assign sh_rxd    = loop ? sh_txd : rxd_pin;

  // checks
  a_r2_tx_bound: assert property (@(posedge clk) disable iff (!rst_n) tx_count <= FULL);
  a_r2_rx_bound: assert property (@(posedge clk) disable iff (!rst_n) rx_count <= FULL);
  a_r4_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fl |=> (tx_count == '0) && !tx_ovf);
  a_r5_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fl |=> (rx_count == '0) && !rx_ovf);
  a_r6_tx_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !tx_fl) |=> tx_ovf);
  a_r6_tx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == FULL && tx_push && !tx_pop && !tx_fl) |=> (tx_count == FULL) && tx_ovf);
  a_r7_rx_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0 && rx_pop && !rx_push && !rx_fl) |=> (rx_count == '0));

endmodule

// File: tb/serial_fifo_ctl_tb.sv
module serial_fifo_ctl_tb;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [7:0] reg_wdata = 0; logic [7:0] reg_rdata;
  logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [7:0] tx_data = 0, rx_data = 0, tx_q, rx_q;
  logic [6:0] tx_count, rx_count;
  logic tx_low, tx_ovf, rx_ovf;
  logic sh_txd = 0, rxd_pin = 1, cts_pin_n = 1;
  logic txd_pin, sh_rxd, cts_int_n, rts_pin_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_fifo_ctl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk) begin reg_wr = 1; reg_wdata = v; end
    @(negedge clk) reg_wr = 0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk) begin tx_push = 1; tx_data = b; end
    @(negedge clk) tx_push = 0;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk) begin rx_push = 1; rx_data = b; end
    @(negedge clk) rx_push = 0;
  endtask

  task automatic pop_tx(output logic [7:0] b);
    @(negedge clk) begin b = tx_q; tx_pop = 1; end
    @(negedge clk) tx_pop = 0;
  endtask

  task automatic pop_rx(output logic [7:0] b);
    @(negedge clk) begin b = rx_q; rx_pop = 1; end
    @(negedge clk) rx_pop = 0;
  endtask

  task automatic flush_all();
    wr_ctrl(8'h06);
    wr_ctrl(8'h00);
  endtask

  task automatic t_reset();
    chk(reg_rdata == 8'h00, "R1 ctrl", reg_rdata, 0);
    chk(tx_count == 0 && rx_count == 0, "R1 counts", tx_count + rx_count, 0);
    chk(!tx_ovf && !rx_ovf, "R1 ovf", tx_ovf + rx_ovf, 0);
    wr_ctrl(8'hFF);
    chk(reg_rdata == 8'h3F, "R1 readback", reg_rdata, 8'h3F);
    wr_ctrl(8'h00);
  endtask

  task automatic t_order();
    logic [7:0] b;
    for (int i = 0; i < 5; i++) push_tx(8'hA0 + 8'(i));
    for (int i = 0; i < 5; i++) push_rx(8'h30 + 8'(i * 3));
    chk(tx_count == 5, "R2 tx count", tx_count, 5);
    for (int i = 0; i < 5; i++) begin
      pop_tx(b); chk(b == 8'hA0 + 8'(i), "R2 tx order", b, 8'hA0 + i);
    end
    for (int i = 0; i < 5; i++) begin
      pop_rx(b); chk(b == 8'h30 + 8'(i * 3), "R2 rx order", b, 8'h30 + i * 3);
    end
  endtask

  task automatic t_trigger();
    int lv [4] = '{32, 16, 2, 0};
    for (int c = 0; c < 4; c++) begin
      flush_all();
      wr_ctrl(8'(c << 4));
      for (int i = 0; i < lv[c]; i++) push_tx(8'(i));
      chk(tx_low == 1, "R3 at threshold", tx_low, 1);
      push_tx(8'h55);
      chk(tx_low == 0, "R3 above threshold", tx_low, 0);
    end
    wr_ctrl(8'h00);
    flush_all();
  endtask

  task automatic t_full_flush();
    logic [7:0] b;
    for (int i = 0; i < 64; i++) push_tx(8'(i + 1));
    chk(tx_count == 64 && !tx_ovf, "R2 full no ovf", tx_count, 64);
    push_tx(8'hEE);
    chk(tx_count == 64, "R6 drop count", tx_count, 64);
    chk(tx_ovf == 1, "R6 ovf set", tx_ovf, 1);
    pop_tx(b); chk(b == 8'h01, "R6 data intact", b, 1);
    repeat (3) @(negedge clk);
    chk(tx_ovf == 1, "R6 ovf sticky", tx_ovf, 1);
    push_rx(8'h77);
    wr_ctrl(8'h04);
    push_tx(8'h11);
    chk(tx_count == 0 && !tx_ovf, "R4 tx held empty", tx_count, 0);
    chk(rx_count == 1, "R4 rx untouched", rx_count, 1);
    wr_ctrl(8'h00);
    wr_ctrl(8'h02);
    push_rx(8'h22);
    chk(rx_count == 0, "R5 rx held empty", rx_count, 0);
    wr_ctrl(8'h00);
    push_rx(8'h99);
    pop_rx(b); chk(b == 8'h99, "R5 after flush", b, 8'h99);
  endtask

  task automatic t_empty_pop();
    logic [7:0] b;
    chk(rx_q == 0 && tx_q == 0, "R7 empty q zero", rx_q, 0);
    pop_rx(b);
    chk(rx_count == 0, "R7 rx count stays", rx_count, 0);
    pop_tx(b);
    chk(tx_count == 0 && b == 0, "R7 tx empty pop", tx_count, 0);
  endtask

  task automatic t_modem();
    logic [7:0] b;
    wr_ctrl(8'h00);
    @(negedge clk) cts_pin_n = 1;
    #1 chk(cts_int_n == 0, "R8 cts forced", cts_int_n, 0);
    for (int i = 0; i < 60; i++) push_rx(8'(i));
    chk(rts_pin_n == 0, "R8 rts forced low", rts_pin_n, 0);
    wr_ctrl(8'h08);
    chk(rts_pin_n == 1, "R9 rts at 60", rts_pin_n, 1);
    pop_rx(b);
    chk(rts_pin_n == 0, "R9 rts at 59", rts_pin_n, 0);
    #1 chk(cts_int_n == 1, "R9 cts follows pin hi", cts_int_n, 1);
    @(negedge clk) cts_pin_n = 0;
    #1 chk(cts_int_n == 0, "R9 cts follows pin lo", cts_int_n, 0);
    wr_ctrl(8'h09);
    @(negedge clk) cts_pin_n = 1;
    #1 chk(cts_int_n == 0, "R10 cts from rts 59", cts_int_n, 0);
    push_rx(8'h01);
    chk(cts_int_n == 1, "R10 cts from rts 60", cts_int_n, 1);
    flush_all();
  endtask

  task automatic t_loop();
    wr_ctrl(8'h01);
    @(negedge clk) begin sh_txd = 0; rxd_pin = 1; end
    #1 chk(txd_pin == 1, "R10 pin idle", txd_pin, 1);
    chk(sh_rxd == 0, "R10 loop rx", sh_rxd, 0);
    @(negedge clk) sh_txd = 1;
    #1 chk(sh_rxd == 1, "R10 loop rx 1", sh_rxd, 1);
    wr_ctrl(8'h00);
    @(negedge clk) begin sh_txd = 0; rxd_pin = 0; end
    #1 chk(txd_pin == 0 && sh_rxd == 0, "R10 normal path", txd_pin, 0);
    @(negedge clk) rxd_pin = 1;
    #1 chk(sh_rxd == 1, "R10 normal rx pin", sh_rxd, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_order();
    t_trigger();
    t_full_flush();
    t_empty_pop();
    t_modem();
    t_loop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule